// File: doc/BRIEF.md
# Lock-Protected System Control Registers

A 32-bit memory-mapped control and status block on a simple register bus (address, write strobe, write data, read strobe, read data). It occupies a 4 KB window at a base address given by a parameter. The register offset is the bus address minus that base. The block provides:

- a read-only identification word,
- an LED register that drives an output bus,
- two configuration words,
- two flag words, each changed through its own set address and its own clear address,
- a reset-control register.

Writes to the reset-control register are accepted only while a lock register holds a magic key. An accepted write with bit 8 set produces a one-cycle board-reset request. A number of status and oscillator offsets read as fixed constants or zero and ignore writes. Accesses inside the window to offsets that are not mapped return zero and raise a one-cycle error pulse.

Read data is registered. The value for a read strobed in one cycle appears on the read-data port in the next cycle. The error pulse and the reset request also appear one cycle after the access that caused them.

Top module: `sysctl_regs`

## Requirements
- R1: Offset 0x00 reads ID_VALUE. After reset, the LED, lock, configuration, flag and reset-control registers all read 0, and led_o is 0.
- R2: Offset 0x08 is a read/write register whose value drives led_o. led_o changes only on a write to 0x08.
- R3: A write to 0x20 stores 0xA05F when the data is exactly 0x0000A05F. Any other data stores data[15:0] & 0x7FFF. A read of 0x20 returns the stored 16-bit value zero-extended.
- R4: A write to 0x40 updates the reset-control register only while the lock holds 0xA05F. Otherwise the write is ignored. A read of 0x40 returns the register.
- R5: An accepted write to 0x40 with bit 8 set drives board_rst_o high for exactly the following cycle.
- R6: Offset 0x30 reads the first flag word. A write to 0x30 ORs the data into it, and a write to 0x34 clears the bits that are 1 in the data.
- R7: The second flag word reads at 0x38, is set by writes to 0x38 and is cleared by writes to 0x3C. It is independent of the first flag word.
- R8: Offsets 0x28 and 0x2C are read/write configuration words.
- R9: The following offsets read as fixed constants:
  - 0x44 reads 1,
  - 0x50 reads 0x00001000,
  - 0x84 reads 0x02000000,
  - 0x88 reads 0xFF000000,
  - 0x04, 0x0C–0x1C, 0x24, 0x48–0x74, 0x80, 0x8C–0x9C and 0xC0–0xD0 (word-aligned) read 0.
  
  Writes to 0x0C–0x1C, 0x44, 0x4C–0x54, 0x64–0x74 and 0x80–0x9C are accepted and have no effect. None of these accesses raises err_o.
- R10: Inside the window, a read of an offset outside the readable set (0x34, 0x3C, any unaligned offset, anything above 0xD0 and not listed) returns 0. A write outside the writable set (0x00, 0x04, and the same kinds of unlisted offsets) changes nothing. Both raise err_o for the one cycle after the access.
- R11: Accesses whose address lies outside [BASE_ADDR, BASE_ADDR+4096) change nothing, read 0 and raise no error.
- R12: rd_data_o carries the read value in the cycle after rd_en_i and is 0 in any cycle not preceded by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Bus byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| led_o | output | 32 | LED register contents |
| board_rst_o | output | 1 | One-cycle board-reset request |
| err_o | output | 1 | One-cycle unmapped-access error |

## Verification
The hardest state to reach is an accepted reset-control write. It needs the lock to hold the exact 32-bit key, and a near miss must leave the block locked.

The stimulus works through that sequence step by step:
- It writes 0x0001A05F to the lock, which stores 0x205F and stays locked.
- It tries a reset-control write and confirms it is refused.
- It unlocks and writes a level without bit 8, then a level with bit 8, watching the reset pulse rise and fall.
- It relocks and confirms that a further write is refused again.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW    = 32;
  localparam int OFF_W = 12;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_LED, SEL_LOCK, SEL_CFG0, SEL_CFG1,
    SEL_FLG_SET, SEL_FLG_CLR, SEL_NVF_SET, SEL_NVF_CLR, SEL_RSTCTL, SEL_CONST
  } sel_e;

  function automatic logic zero_rd(input logic [OFF_W-1:0] off);
    return off inside {12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
                       12'h024, 12'h048, 12'h04C, 12'h054, 12'h058, 12'h05C,
                       12'h060, 12'h064, 12'h068, 12'h06C, 12'h070, 12'h074,
                       12'h080, 12'h08C, 12'h090, 12'h094, 12'h098, 12'h09C,
                       12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0};
  endfunction

  function automatic logic nop_wr(input logic [OFF_W-1:0] off);
    return off inside {12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h044,
                       12'h04C, 12'h050, 12'h054, 12'h064, 12'h068, 12'h06C,
                       12'h070, 12'h074, 12'h080, 12'h084, 12'h088, 12'h08C,
                       12'h090, 12'h094, 12'h098, 12'h09C};
  endfunction

  function automatic logic [DW-1:0] const_val(input logic [OFF_W-1:0] off);
    case (off)
      12'h044: return 32'h0000_0001;
      12'h050: return 32'h0000_1000;
      12'h084: return 32'h0200_0000;
      12'h088: return 32'hFF00_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h1000_0000
) (
  input  logic [31:0]      addr_i,
  output logic             in_win_o,
  output logic [OFF_W-1:0] off_o,
  output sel_e             sel_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o
);
  localparam logic [32:0] WIN_BYTES = 33'(1) << OFF_W;

  logic [31:0] diff;
  assign diff     = addr_i - BASE_ADDR;
  assign in_win_o = {1'b0, diff} < WIN_BYTES;
  assign off_o    = diff[OFF_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (in_win_o) begin
      case (off_o)
        12'h000: sel_o = SEL_ID;
        12'h008: sel_o = SEL_LED;
        12'h020: sel_o = SEL_LOCK;
        12'h028: sel_o = SEL_CFG0;
        12'h02C: sel_o = SEL_CFG1;
        12'h030: sel_o = SEL_FLG_SET;
        12'h034: sel_o = SEL_FLG_CLR;
        12'h038: sel_o = SEL_NVF_SET;
        12'h03C: sel_o = SEL_NVF_CLR;
        12'h040: sel_o = SEL_RSTCTL;
        12'h044, 12'h050, 12'h084, 12'h088: sel_o = SEL_CONST;
        default: sel_o = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    rd_ok_o = in_win_o && ((sel_o inside {SEL_ID, SEL_LED, SEL_LOCK, SEL_CFG0, SEL_CFG1,
                                          SEL_FLG_SET, SEL_NVF_SET, SEL_RSTCTL, SEL_CONST})
                           || zero_rd(off_o));
    wr_ok_o = in_win_o && ((sel_o inside {SEL_LED, SEL_LOCK, SEL_CFG0, SEL_CFG1, SEL_FLG_SET,
                                          SEL_FLG_CLR, SEL_NVF_SET, SEL_NVF_CLR, SEL_RSTCTL})
                           || nop_wr(off_o));
  end
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic [15:0]   lock_o,
  output logic          unlocked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_o <= '0;
    else if (wr_i) lock_o <= (data_i == DW'(UNLOCK_KEY)) ? UNLOCK_KEY
                                                          : (data_i[15:0] & 16'h7FFF);
  end

  assign unlocked_o = (lock_o == UNLOCK_KEY);
endmodule

// File: rtl/sysctl_flagword.sv
module sysctl_flagword
  import sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (set_i)  q_o <= q_o | data_i;
    else if (clr_i)  q_o <= q_o & ~data_i;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
  parameter logic [31:0] ID_VALUE  = 32'h4110_0178
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [31:0] rd_data_o,
  output logic [31:0] led_o,
  output logic        board_rst_o,
  output logic        err_o
);
  localparam int NFLAG   = 2;
  localparam int RST_BIT = 8;

  logic             in_win, rd_ok, wr_ok;
  logic [OFF_W-1:0] off;
  sel_e             sel;

  sysctl_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(addr_i), .in_win_o(in_win), .off_o(off), .sel_o(sel),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
  );

  logic [15:0] lock_val;
  logic        unlocked;

  sysctl_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_en_i && sel == SEL_LOCK),
    .data_i(wr_data_i), .lock_o(lock_val), .unlocked_o(unlocked)
  );

  logic [NFLAG-1:0]         flg_set, flg_clr;
  logic [NFLAG-1:0][DW-1:0] flags;

  assign flg_set[0] = wr_en_i && sel == SEL_FLG_SET;
  assign flg_clr[0] = wr_en_i && sel == SEL_FLG_CLR;
  assign flg_set[1] = wr_en_i && sel == SEL_NVF_SET;
  assign flg_clr[1] = wr_en_i && sel == SEL_NVF_CLR;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sysctl_flagword u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flg_set[g]), .clr_i(flg_clr[g]),
      .data_i(wr_data_i), .q_o(flags[g])
    );
  end

  logic [DW-1:0] led_q, cfg0_q, cfg1_q, rstlvl_q, rd_mux;
  logic          rst_acc;

  assign rst_acc = wr_en_i && sel == SEL_RSTCTL && unlocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q    <= '0;
      cfg0_q   <= '0;
      cfg1_q   <= '0;
      rstlvl_q <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_LED)  led_q    <= wr_data_i;
      if (sel == SEL_CFG0) cfg0_q   <= wr_data_i;
      if (sel == SEL_CFG1) cfg1_q   <= wr_data_i;
      if (rst_acc)         rstlvl_q <= wr_data_i;
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:      rd_mux = ID_VALUE;
      SEL_LED:     rd_mux = led_q;
      SEL_LOCK:    rd_mux = {16'b0, lock_val};
      SEL_CFG0:    rd_mux = cfg0_q;
      SEL_CFG1:    rd_mux = cfg1_q;
      SEL_FLG_SET: rd_mux = flags[0];
      SEL_NVF_SET: rd_mux = flags[1];
      SEL_RSTCTL:  rd_mux = rstlvl_q;
      SEL_CONST:   rd_mux = const_val(off);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o   <= '0;
      err_o       <= 1'b0;
      board_rst_o <= 1'b0;
    end else begin
      rd_data_o   <= (rd_en_i && rd_ok) ? rd_mux : '0;
      err_o       <= in_win && ((rd_en_i && !rd_ok) || (wr_en_i && !wr_ok));
      board_rst_o <= rst_acc && wr_data_i[RST_BIT];
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
  import sysctl_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [31:0]   wr_data_i,
  input logic [31:0]   led_o,
  input logic          board_rst_o,
  input logic          err_o,
  input sel_e          sel,
  input logic          unlocked,
  input logic [DW-1:0] flag0,
  input logic [DW-1:0] rstlvl
);
  // R5
  rst_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_o |-> $past(wr_en_i && sel == SEL_RSTCTL && unlocked && wr_data_i[8]));

  // R3
  lock_open_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && !$past(unlocked)) |-> $past(wr_en_i && sel == SEL_LOCK && wr_data_i == 32'h0000_A05F));

  // R2
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel == SEL_LED) |=> $stable(led_o));

  // R10
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_en_i || wr_en_i));

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_FLG_SET) |=> ((flag0 & $past(wr_data_i)) == $past(wr_data_i)));

  // R4
  rstlvl_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(rstlvl));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .wr_data_i(wr_data_i), .led_o(led_o), .board_rst_o(board_rst_o), .err_o(err_o),
  .sel(sel), .unlocked(unlocked), .flag0(flags[0]), .rstlvl(rstlvl_q)
);

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] IDV  = 32'hC0DE_0A15;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata, led;
  logic        brst, err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysctl_regs #(.BASE_ADDR(BASE), .ID_VALUE(IDV)) u_sysctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .led_o(led), .board_rst_o(brst), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_abs(input logic [31:0] a, input logic [31:0] d,
                        output logic rst_seen, output logic err_seen);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rst_seen = brst; err_seen = err;
  endtask

  task automatic rd_abs(input logic [31:0] a, output logic [31:0] d, output logic err_seen);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = rdata; err_seen = err;
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    logic r, e;
    wr_abs(BASE + 32'(off), d, r, e);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] off, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd_abs(BASE + 32'(off), d, e);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 id", 12'h000, IDV);
    chk("R1 led_o", led, 32'h0);
    rd_chk("R1 lock", 12'h020, 32'h0);
    rd_chk("R1 flags", 12'h030, 32'h0);
    rd_chk("R1 rstctl", 12'h040, 32'h0);
    @(negedge clk);
    chk("R12 idle rd_data", rdata, 32'h0);
  endtask

  task automatic t_led;
    wr(12'h008, 32'hA5A5_0F0F);
    chk("R2 led_o", led, 32'hA5A5_0F0F);
    rd_chk("R2 readback", 12'h008, 32'hA5A5_0F0F);
  endtask

  task automatic t_lock;
    wr(12'h020, 32'h0001_A05F);
    rd_chk("R3 near key", 12'h020, 32'h0000_205F);
    wr(12'h020, 32'hFFFF_FFFF);
    rd_chk("R3 masked", 12'h020, 32'h0000_7FFF);
    wr(12'h020, 32'h0000_A05F);
    rd_chk("R3 key", 12'h020, 32'h0000_A05F);
  endtask

  task automatic t_rstctl;
    logic r, e;
    wr(12'h020, 32'h0000_1234);
    wr_abs(BASE + 32'h40, 32'h0000_01FF, r, e);
    chk("R4 locked no pulse", {31'b0, r}, 32'h0);
    rd_chk("R4 locked ignored", 12'h040, 32'h0);
    wr(12'h020, 32'h0000_A05F);
    wr_abs(BASE + 32'h40, 32'h0000_00FF, r, e);
    chk("R5 no bit8 no pulse", {31'b0, r}, 32'h0);
    rd_chk("R4 accepted", 12'h040, 32'h0000_00FF);
    wr_abs(BASE + 32'h40, 32'h0000_0100, r, e);
    chk("R5 pulse high", {31'b0, r}, 32'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, brst}, 32'h0);
    rd_chk("R4 level kept", 12'h040, 32'h0000_0100);
    wr(12'h020, 32'h0);
    wr(12'h040, 32'h0000_0003);
    rd_chk("R4 relocked ignored", 12'h040, 32'h0000_0100);
  endtask

  task automatic t_flags;
    wr(12'h030, 32'h0000_00F0);
    wr(12'h030, 32'h0000_000F);
    rd_chk("R6 set or", 12'h030, 32'h0000_00FF);
    wr(12'h034, 32'h0000_003C);
    rd_chk("R6 clear", 12'h030, 32'h0000_00C3);
    rd_chk("R7 independent", 12'h038, 32'h0);
    wr(12'h038, 32'h8000_0001);
    wr(12'h03C, 32'h0000_0001);
    rd_chk("R7 set clear", 12'h038, 32'h8000_0000);
    rd_chk("R7 first untouched", 12'h030, 32'h0000_00C3);
  endtask

  task automatic t_cfg;
    wr(12'h028, 32'h1234_5678);
    wr(12'h02C, 32'h9ABC_DEF0);
    rd_chk("R8 cfg0", 12'h028, 32'h1234_5678);
    rd_chk("R8 cfg1", 12'h02C, 32'h9ABC_DEF0);
  endtask

  task automatic t_const;
    logic r, e; logic [31:0] d;
    rd_chk("R9 0x44", 12'h044, 32'h1);
    rd_chk("R9 0x50", 12'h050, 32'h0000_1000);
    rd_chk("R9 0x84", 12'h084, 32'h0200_0000);
    rd_chk("R9 0x88", 12'h088, 32'hFF00_0000);
    wr_abs(BASE + 32'h50, 32'hFFFF_FFFF, r, e);
    chk("R9 write no err", {31'b0, e}, 32'h0);
    rd_chk("R9 0x50 after write", 12'h050, 32'h0000_1000);
    wr(12'h00C, 32'h5);
    rd_abs(BASE + 32'h0C, d, e);
    chk("R9 osc zero", d, 32'h0);
    chk("R9 osc no err", {31'b0, e}, 32'h0);
    rd_abs(BASE + 32'hD0, d, e);
    chk("R9 test osc no err", {31'b0, e}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic r, e; logic [31:0] d;
    rd_abs(BASE + 32'h34, d, e);
    chk("R10 rd clr addr data", d, 32'h0);
    chk("R10 rd clr addr err", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R10 err one cycle", {31'b0, err}, 32'h0);
    rd_abs(BASE + 32'h0A, d, e);
    chk("R10 unaligned err", {31'b0, e}, 32'h1);
    wr_abs(BASE + 32'h00, 32'hDEAD_BEEF, r, e);
    chk("R10 wr id err", {31'b0, e}, 32'h1);
    rd_chk("R10 id unchanged", 12'h000, IDV);
    wr_abs(BASE + 32'hF00, 32'h1, r, e);
    chk("R10 wr high err", {31'b0, e}, 32'h1);
  endtask

  task automatic t_window;
    logic r, e; logic [31:0] d;
    wr_abs(BASE + 32'h1008, 32'hFFFF_FFFF, r, e);
    chk("R11 no err", {31'b0, e}, 32'h0);
    chk("R11 led unchanged", led, 32'hA5A5_0F0F);
    rd_abs(BASE - 32'h4, d, e);
    chk("R11 read zero", d, 32'h0);
    chk("R11 read no err", {31'b0, e}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_led;
    t_lock;
    t_rstctl;
    t_flags;
    t_cfg;
    t_const;
    t_unmapped;
    t_window;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule